// File: doc/BRIEF.md
# Mains Supervisor with Overvoltage Latch

This block supervises a power converter's input rail. It acts on two comparator flags taken from a single sense pin. The first flag means the rectified bulk voltage sits below the brown-out level. The second means the pin has risen above the overvoltage level. Each flag must hold steady for a fixed confirmation window before the block acts on it. Any toggle inside that window restarts the count, so short noise spikes are filtered out.

A confirmed brown-out stops switching, and the block recovers from it by itself. A confirmed overvoltage sets a latch that keeps switching off. Only a supply reset or a confirmed brown-out clears that latch. The block drives four outputs:
- a run permit for the gate driver;
- the latch status;
- an enable for the hysteresis current source, which is active only while the rail is confirmed healthy;
- a one-cycle restart request to the startup sequencer. This request tells the sequencer to run the full startup sequence with soft-start whenever switching becomes permitted again.

Top module: `mains_guard`

## Requirements
- R1: While reset is held and right after it, run_o, latched_o, hyst_en_o and restart_o are all 0. The rail is treated as being in brown-out until proven healthy.
- R2: Once bulk_low_i has been 0 for CONFIRM_CYCLES consecutive sampled cycles, the brown-out state ends. hyst_en_o becomes 1, and run_o becomes 1 unless the latch is set.
- R3: Once bulk_low_i has been 1 for CONFIRM_CYCLES consecutive sampled cycles, the brown-out state is entered, and run_o and hyst_en_o become 0.
- R4: An input that differs from its confirmed state for fewer than CONFIRM_CYCLES consecutive cycles has no effect, and the count restarts from zero when the input returns.
- R5: Once ovp_hi_i has been 1 for CONFIRM_CYCLES consecutive cycles, latched_o becomes 1 one cycle later, and run_o becomes 0.
- R6: latched_o stays 1 after ovp_hi_i returns to 0, as long as no clear occurs.
- R7: A cycle with supply_rst_i at 1 clears latched_o on the next clock edge.
- R8: A confirmed brown-out clears latched_o one cycle after hyst_en_o falls.
- R9: restart_o is a single-cycle pulse. It is high exactly in the first cycle in which run_o is 1 after being 0.
- R10: hyst_en_o reflects only the confirmed brown-out state and does not depend on the latch.
- R11: A clear takes priority over setting the latch. If the overvoltage is still confirmed when supply_rst_i is released, the latch sets again on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bulk_low_i | input | 1 | Comparator flag: bulk image below brown-out level |
| ovp_hi_i | input | 1 | Comparator flag: pin above overvoltage level |
| supply_rst_i | input | 1 | Supply fell below its logic reset level (synchronous) |
| run_o | output | 1 | Switching permitted |
| latched_o | output | 1 | Overvoltage latch is set |
| hyst_en_o | output | 1 | Enable for the brown-out hysteresis current source |
| restart_o | output | 1 | One-cycle request for a full startup sequence |

## Verification
The bound checker monitors several properties on every cycle:
- the run permit is never high while the latch is set or the rail is in brown-out;
- the restart pulse is one cycle long and only appears on a rising run permit;
- the latch holds while no clear is present;
- the latch can only rise after a cycle with no clear.

The bench scenarios are needed for the timing behaviour: the exact confirmation length, the restart of the count on a glitch, and the relatching when a supply reset is released while the overvoltage persists.

// File: rtl/mains_guard_pkg.sv
package mains_guard_pkg;

   // Pair of supervision conditions carried between stages
   typedef struct packed {
      logic under;   // bulk rail low
      logic over;    // pin above overvoltage level
   } rail_cond_t;

   localparam rail_cond_t RAIL_RST = '{under: 1'b1, over: 1'b0};

endpackage

// File: rtl/mg_sync.sv
module mg_sync #(
   parameter int  STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= {STAGES{RST_VAL}};
            else        sr <= {sr[STAGES-2+((STAGES==1)?1:0):0], d_i};
         end
         assign q_o = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mg_confirm.sv
module mg_confirm #(
   parameter int   DELAY   = 8,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic state_o
);
   localparam int CW = (DELAY > 2) ? $clog2(DELAY) : 1;
   localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

   logic [CW-1:0] cnt;
   logic          state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RST_VAL;
         cnt   <= '0;
      end else if (raw_i == state) begin
         cnt <= '0;
      end else if (cnt == LAST) begin
         state <= raw_i;
         cnt   <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign state_o = state;
endmodule

// File: rtl/mg_core.sv
module mg_core (
   input  logic                        clk,
   input  logic                        rst_n,
   input  mains_guard_pkg::rail_cond_t cond_i,
   input  logic                        supply_rst_i,
   output logic                        run_o,
   output logic                        latched_o,
   output logic                        hyst_en_o,
   output logic                        restart_o
);
   logic latch_q;
   logic run_prev;
   logic clear;
   logic run_now;

   assign clear   = supply_rst_i | cond_i.under;
   assign run_now = ~cond_i.under & ~latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q  <= 1'b0;
         run_prev <= 1'b0;
      end else begin
         latch_q  <= clear ? 1'b0 : (latch_q | cond_i.over);
         run_prev <= run_now;
      end
   end

   assign run_o     = run_now;
   assign latched_o = latch_q;
   assign hyst_en_o = ~cond_i.under;
   assign restart_o = run_now & ~run_prev;
endmodule

// File: rtl/mains_guard.sv
module mains_guard #(
   parameter int CONFIRM_CYCLES = 7500,
   parameter int SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bulk_low_i,
   input  logic ovp_hi_i,
   input  logic supply_rst_i,
   output logic run_o,
   output logic latched_o,
   output logic hyst_en_o,
   output logic restart_o
);
   import mains_guard_pkg::*;

   generate
      if (CONFIRM_CYCLES < 2) begin : g_bad_delay
         $error("CONFIRM_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
   endgenerate

   rail_cond_t synced;
   rail_cond_t confirmed;

   mg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RAIL_RST.under)) u_sync_under (
      .clk(clk), .rst_n(rst_n), .d_i(bulk_low_i), .q_o(synced.under));
   mg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RAIL_RST.over)) u_sync_over (
      .clk(clk), .rst_n(rst_n), .d_i(ovp_hi_i), .q_o(synced.over));

   mg_confirm #(.DELAY(CONFIRM_CYCLES), .RST_VAL(RAIL_RST.under)) u_conf_under (
      .clk(clk), .rst_n(rst_n), .raw_i(synced.under), .state_o(confirmed.under));
   mg_confirm #(.DELAY(CONFIRM_CYCLES), .RST_VAL(RAIL_RST.over)) u_conf_over (
      .clk(clk), .rst_n(rst_n), .raw_i(synced.over), .state_o(confirmed.over));

   mg_core u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .cond_i       (confirmed),
      .supply_rst_i (supply_rst_i),
      .run_o        (run_o),
      .latched_o    (latched_o),
      .hyst_en_o    (hyst_en_o),
      .restart_o    (restart_o)
   );
endmodule

// File: rtl/mains_guard_chk.sv
module mains_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic bulk_low_i,
   input logic ovp_hi_i,
   input logic supply_rst_i,
   input logic run_o,
   input logic latched_o,
   input logic hyst_en_o,
   input logic restart_o
);
   AST_RUN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> (!latched_o && hyst_en_o)); // R2
   AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |=> !restart_o); // R9
   AST_RESTART_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> (run_o && !$past(run_o))); // R9
   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (latched_o && !supply_rst_i && hyst_en_o) |=> latched_o); // R6
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latched_o) |-> (!$past(supply_rst_i) && $past(hyst_en_o))); // R11
   AST_SUPPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      supply_rst_i |=> !latched_o); // R7
endmodule

bind mains_guard mains_guard_chk chk_i (.*);

// File: tb/mains_guard_tb_top.sv
module mains_guard_tb_top;
   localparam int D = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bulk_low = 1'b1, ovp_hi = 1'b0, srst = 1'b0;
   logic run, latched, hyst, restart;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   mains_guard #(.CONFIRM_CYCLES(D), .SYNC_STAGES(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bulk_low_i(bulk_low), .ovp_hi_i(ovp_hi),
      .supply_rst_i(srst), .run_o(run), .latched_o(latched),
      .hyst_en_o(hyst), .restart_o(restart));

   // {bulk_low, ovp_hi, srst, hold[7:0], exp_run, exp_latched, exp_hyst}
   localparam int NV = 16;
   localparam logic [13:0] VEC [0:NV-1] = '{
      {3'b100, 8'd6,  3'b000},   // R3 stays in brown-out
      {3'b000, 8'd3,  3'b000},   // R2 not yet confirmed
      {3'b000, 8'd1,  3'b101},   // R2 confirmed healthy
      {3'b100, 8'd3,  3'b101},   // R4 short dip ignored
      {3'b000, 8'd2,  3'b101},   // R4
      {3'b100, 8'd3,  3'b101},   // R4 count restarted
      {3'b010, 8'd3,  3'b101},   // R5 not yet
      {3'b010, 8'd2,  3'b011},   // R5 latched, R10 hyst unaffected
      {3'b000, 8'd10, 3'b011},   // R6 latch holds
      {3'b001, 8'd1,  3'b101},   // R7 supply reset clears
      {3'b000, 8'd2,  3'b101},   // R7
      {3'b010, 8'd5,  3'b011},   // R5 again
      {3'b000, 8'd5,  3'b011},   // R6
      {3'b100, 8'd4,  3'b010},   // R3 brown-out, R10
      {3'b100, 8'd1,  3'b000},   // R8 brown-out clears latch
      {3'b000, 8'd4,  3'b101}    // R2 recovery
   };

   task automatic check(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 run", run, 1'b0);
      check("R1 latched", latched, 1'b0);
      check("R1 hyst", hyst, 1'b0);
      check("R1 restart", restart, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 run after release", run, 1'b0);

      for (int i = 0; i < NV; i++) begin
         {bulk_low, ovp_hi, srst} = VEC[i][13:11];
         repeat (int'(VEC[i][10:3])) @(posedge clk);
         @(negedge clk);
         check($sformatf("vec%0d run", i), run, VEC[i][2]);
         check($sformatf("vec%0d latched", i), latched, VEC[i][1]);
         check($sformatf("vec%0d hyst", i), hyst, VEC[i][0]);
      end

      // R9: restart pulse on recovery from brown-out
      bulk_low = 1'b1;
      repeat (D + 2) @(negedge clk);
      check("R9 run off", run, 1'b0);
      bulk_low = 1'b0;
      begin
         int pulses = 0;
         for (int c = 0; c < D + 4; c++) begin
            @(negedge clk);
            if (restart) begin
               pulses++;
               check("R9 run high with restart", run, 1'b1);
            end
         end
         check("R9 single pulse", pulses == 1, 1'b1);
      end

      // R11: clear beats set, relatch on release
      ovp_hi = 1'b1;
      srst   = 1'b1;
      repeat (D + 4) @(negedge clk);
      check("R11 held clear", latched, 1'b0);
      srst = 1'b0;
      @(negedge clk);
      check("R11 relatched", latched, 1'b1);
      check("R11 run off", run, 1'b0);
      ovp_hi = 1'b0;
      repeat (D + 1) @(negedge clk);
      srst = 1'b1;
      @(negedge clk);
      srst = 1'b0;
      check("R7 cleared", latched, 1'b0);
      check("R9 restart after clear", restart, 1'b1);
      @(negedge clk);
      check("R9 pulse ended", restart, 1'b0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule